// File: doc/BRIEF.md
# Banked GPIO Register File with Password-Gated Pin Lock

This block is the register file of a general-purpose I/O controller. It holds up to eight banks of 32 pins each. Every pin has a control word whose lowest bit picks its direction. Each bank has an output word that software changes only through write-one-to-set and write-one-to-clear ports. Each bank also has an input word, taken from the pads through a two-stage synchronizer. The pin side gives an output vector and an output-enable vector that go straight to the pad ring.

A per-bank lock word protects pin configuration. A set lock bit freezes that pin's direction and output value. Software can rewrite a lock word only if the write that comes right before it puts a fixed password value into a global password register. Any other write in between disarms the gate. After reset every pin is locked, set as an input, and driving low.

The register bus is a plain 32-bit word bus with no back-pressure. A write commits on the clock edge where the write enable is high. Read data follows the address combinationally and has no handshake.

Top module: `gpio_bankfile`

## Requirements
- R1: After reset every lock word reads all ones, every control word reads 1 (input), every output word reads zero, pin_oe is all zeros, pin_out is all zeros, and the password gate is disarmed.
- R2: A write to the lock word of bank b (address 0x500 + 4*b) replaces that word only when the previous bus write was the value 0x00A5A501 to the password address 0x520. Otherwise the lock write is ignored. Lock bit n set protects pin n of bank b.
- R3: Any bus write other than a correct password write disarms the gate. This includes a lock write, whether or not it was accepted, and a password write with a wrong value. Cycles with no write leave the gate as it is.
- R4: The control word of pin p = 32*b + n is at 0x100 + 4*p. Bit 0 of the written value sets the direction (1 input, 0 output). A read returns the direction in bit 0 and zeros in bits 31:1. pin_oe[p] is the inverse of the direction.
- R5: Writing to 0x40 + 4*b sets every output bit of bank b whose written bit is 1. Written zeros leave bits unchanged.
- R6: Writing to 0x60 + 4*b clears every output bit of bank b whose written bit is 1. Written zeros leave bits unchanged.
- R7: A pin whose lock bit is set ignores writes to its control word and to its bit in the set and clear words. Unlocked pins hit by the same set or clear write are still updated.
- R8: The output word of bank b reads at 0x00 + 4*b, and pin_out bits [32*b +: 32] equal it at all times.
- R9: The input word of bank b reads at 0x20 + 4*b. It shows pin_in as sampled two clock edges earlier.
- R10: The lock word of bank b reads back at 0x500 + 4*b. The password address, addresses whose low two bits are not zero, addresses of banks at or beyond NUM_BANKS, and every other address read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, commits on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32*NUM_BANKS | Pad input levels |
| pin_out | output | 32*NUM_BANKS | Pad output levels |
| pin_oe | output | 32*NUM_BANKS | Pad output enables, 1 drives the pad |

## Verification
A bad lock word or a stuck armed flag does not show up on the pins at once. It appears only at the next set, clear or control write, which either changes a pin it should not touch or leaves alone a pin it should change. For that reason the bench reads the output word and the pins back after every write, and reads each lock word after every lock attempt. A broken direction bit shows on pin_oe in the cycle after its write. A wrong synchronizer depth shows as input data that arrives one edge early or one edge late.

// File: rtl/gpio_bankfile_pkg.sv
package gpio_bankfile_pkg;
  localparam int BANK_PINS = 32;
  localparam int ADDR_W    = 12;
  localparam logic [31:0] UNLOCK_KEY = 32'h00A5_A501;
  localparam logic [ADDR_W-1:0] KEY_ADDR   = 12'h520;
  localparam logic [ADDR_W-1:0] CTRL_BASE  = 12'h100;
  localparam logic [6:0]        LOCK_GROUP = 7'h28;

  typedef enum logic [2:0] {
    RK_NONE, RK_OUT, RK_IN, RK_SET, RK_CLR, RK_CTRL, RK_LOCK, RK_KEY
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] bank;
    logic [4:0] bit_idx;
  } reg_sel_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bankfile_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam int NPINS = NUM_BANKS * BANK_PINS;

  logic [9:0] pin_idx;
  logic       bank_ok;

  always_comb begin
    pin_idx = addr[11:2] - CTRL_BASE[11:2];
    bank_ok = int'(addr[4:2]) < NUM_BANKS;
    sel     = '{kind: RK_NONE, bank: addr[4:2], bit_idx: 5'd0};
    if (addr[1:0] == 2'b00) begin
      if (addr[11:7] == 5'd0) begin
        if (bank_ok) begin
          unique case (addr[6:5])
            2'd0: sel.kind = RK_OUT;
            2'd1: sel.kind = RK_IN;
            2'd2: sel.kind = RK_SET;
            default: sel.kind = RK_CLR;
          endcase
        end
      end else if (addr >= CTRL_BASE && int'(pin_idx) < NPINS) begin
        sel.kind    = RK_CTRL;
        sel.bank    = pin_idx[7:5];
        sel.bit_idx = pin_idx[4:0];
      end else if (addr[11:5] == LOCK_GROUP) begin
        if (bank_ok) sel.kind = RK_LOCK;
      end else if (addr == KEY_ADDR) begin
        sel.kind = RK_KEY;
      end
    end
  end
endmodule

// File: rtl/gpio_lock_gate.sv
module gpio_lock_gate
  import gpio_bankfile_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  reg_sel_t                       sel,
  input  logic [31:0]                    wdata,
  output logic [NUM_BANKS*BANK_PINS-1:0] lock_flat
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= (sel.kind == RK_KEY) && (wdata == UNLOCK_KEY);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lock
    logic [BANK_PINS-1:0] lock_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= '1;
      else if (wr_en && armed_q && sel.kind == RK_LOCK && sel.bank == 3'(b))
        lock_q <= wdata;
    end
    assign lock_flat[b*BANK_PINS +: BANK_PINS] = lock_q;
  end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_bankfile_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic                 wr_set,
  input  logic                 wr_clr,
  input  logic [4:0]           bit_idx,
  input  logic [31:0]          wdata,
  input  logic [BANK_PINS-1:0] lock,
  input  logic [BANK_PINS-1:0] pad_in,
  output logic [BANK_PINS-1:0] out_q,
  output logic [BANK_PINS-1:0] dir_q,
  output logic [BANK_PINS-1:0] in_sync
);
  logic [BANK_PINS-1:0] meta_q;
  logic [BANK_PINS-1:0] open_bits;

  assign open_bits = wdata & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      if (wr_ctrl && !lock[bit_idx]) dir_q[bit_idx] <= wdata[0];
      if (wr_set)      out_q <= out_q | open_bits;
      else if (wr_clr) out_q <= out_q & ~open_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      in_sync <= '0;
    end else begin
      meta_q  <= pad_in;
      in_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bankfile.sv
module gpio_bankfile
  import gpio_bankfile_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [11:0]                    bus_addr,
  input  logic                           bus_we,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_BANKS*32-1:0]        pin_in,
  output logic [NUM_BANKS*32-1:0]        pin_out,
  output logic [NUM_BANKS*32-1:0]        pin_oe
);
  localparam int NPINS = NUM_BANKS * BANK_PINS;

  reg_sel_t             sel;
  logic [NPINS-1:0]     lock_flat;
  logic [NPINS-1:0]     dir_flat;
  logic [BANK_PINS-1:0] out_w  [NUM_BANKS];
  logic [BANK_PINS-1:0] in_w   [NUM_BANKS];
  logic [BANK_PINS-1:0] lock_w [NUM_BANKS];

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_lock_gate #(.NUM_BANKS(NUM_BANKS)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we),
    .sel       (sel),
    .wdata     (bus_wdata),
    .lock_flat (lock_flat)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    logic [BANK_PINS-1:0] dir_b;
    assign hit = bus_we && (sel.bank == 3'(b));
    assign lock_w[b] = lock_flat[b*BANK_PINS +: BANK_PINS];

    gpio_pin_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (hit && sel.kind == RK_CTRL),
      .wr_set  (hit && sel.kind == RK_SET),
      .wr_clr  (hit && sel.kind == RK_CLR),
      .bit_idx (sel.bit_idx),
      .wdata   (bus_wdata),
      .lock    (lock_w[b]),
      .pad_in  (pin_in[b*BANK_PINS +: BANK_PINS]),
      .out_q   (out_w[b]),
      .dir_q   (dir_b),
      .in_sync (in_w[b])
    );

    assign dir_flat[b*BANK_PINS +: BANK_PINS] = dir_b;
    assign pin_out[b*BANK_PINS +: BANK_PINS]  = out_w[b];
    assign pin_oe[b*BANK_PINS +: BANK_PINS]   = ~dir_b;
  end

  always_comb begin
    unique case (sel.kind)
      RK_OUT:  bus_rdata = out_w[sel.bank];
      RK_IN:   bus_rdata = in_w[sel.bank];
      RK_LOCK: bus_rdata = lock_w[sel.bank];
      RK_CTRL: bus_rdata = {31'd0, dir_flat[{sel.bank, sel.bit_idx}]};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bankfile_chk.sv
module gpio_bankfile_chk #(
  parameter int NUM_BANKS = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_we,
  input logic [11:0]             bus_addr,
  input logic [31:0]             bus_rdata,
  input logic [NUM_BANKS*32-1:0] pin_out,
  input logic [NUM_BANKS*32-1:0] pin_oe,
  input logic [NUM_BANKS*32-1:0] lock_flat
);
  // R2
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> $stable(lock_flat));

  // R7
  locked_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ $past(pin_out)) & $past(lock_flat)) == '0);

  // R7
  locked_oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ $past(pin_oe)) & $past(lock_flat)) == '0);

  // R8
  idle_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> $stable(pin_out));

  // R10
  misaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'd0));
endmodule

bind gpio_bankfile gpio_bankfile_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .lock_flat (lock_flat)
);

// File: tb/gpio_bankfile_tb.sv
module gpio_bankfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_lock [NB];
  logic [31:0] m_dir  [NB];
  logic [31:0] m_out  [NB];
  bit          m_armed;

  gpio_bankfile #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    if (a[1:0] != 0) return "R10";
    if (a < 12'h020) return "R8";
    if (a < 12'h040) return "R9";
    if (a < 12'h060) return "R5";
    if (a < 12'h080) return "R6";
    if (a >= 12'h100 && a < 12'h500) return "R4";
    if (a >= 12'h500 && a < 12'h520) return "R2";
    return "R10";
  endfunction

  function automatic void m_write(logic [11:0] a, logic [31:0] d);
    bit was = m_armed;
    int b;
    m_armed = 0;
    if (a[1:0] != 0) return;
    b = int'(a[4:2]);
    if (a == 12'h520) m_armed = (d == 32'h00A5A501);
    else if (a >= 12'h500 && a < 12'h500 + 4*NB) begin
      if (was) m_lock[b] = d;
    end else if (a >= 12'h040 && a < 12'h040 + 4*NB)
      m_out[b] = m_out[b] | (d & ~m_lock[b]);
    else if (a >= 12'h060 && a < 12'h060 + 4*NB)
      m_out[b] = m_out[b] & ~(d & ~m_lock[b]);
    else if (a >= 12'h100 && a < 12'h100 + 4*NP) begin
      int p = (int'(a) - 'h100) / 4;
      if (!m_lock[p/32][p%32]) m_dir[p/32][p%32] = d[0];
    end
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int b = int'(a[4:2]);
    if (a[1:0] != 0) return 0;
    if (a < 12'h000 + 4*NB) return m_out[b];
    if (a >= 12'h020 && a < 12'h020 + 4*NB) return pin_in[b*32 +: 32];
    if (a >= 12'h100 && a < 12'h100 + 4*NP) begin
      int p = (int'(a) - 'h100) / 4;
      return {31'd0, m_dir[p/32][p%32]};
    end
    if (a >= 12'h500 && a < 12'h500 + 4*NB) return m_lock[b];
    return 0;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, m_read(a));
  endtask

  task automatic pins_chk(string req);
    for (int b = 0; b < NB; b++) begin
      chk(req, pin_out[b*32 +: 32], m_out[b]);
      chk("R4", pin_oe[b*32 +: 32], ~m_dir[b]);
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_lock[b] = '1; m_dir[b] = '1; m_out[b] = '0;
    end
    m_armed = 0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    pins_chk("R1");
    chk("R1", u_dut.pin_oe[31:0], 32'h0);
    rd_chk("R1", 12'h504);
    chk("R1", bus_rdata, 32'hFFFF_FFFF);
    rd_chk("R1", 12'h114);
    chk("R1", bus_rdata, 32'h1);

    // R7 locked bank ignores set
    wr(12'h040, 32'hFFFF_FFFF);
    rd_chk("R7", 12'h000);
    chk("R7", bus_rdata, 32'h0);

    // R2 lock write without key is ignored
    wr(12'h500, 32'h0);
    rd_chk("R2", 12'h500);
    chk("R2", bus_rdata, 32'hFFFF_FFFF);

    // R2 keyed unlock of bank 0
    wr(12'h520, 32'h00A5_A501);
    wr(12'h500, 32'h0);
    rd_chk("R2", 12'h500);
    chk("R2", bus_rdata, 32'h0);

    // R3 lock write consumes the arming
    wr(12'h500, 32'h0000_00FF);
    rd_chk("R3", 12'h500);
    chk("R3", bus_rdata, 32'h0);

    // R4 direction
    wr(12'h10C, 32'hFFFF_FFFE);
    rd_chk("R4", 12'h10C);
    chk("R4", bus_rdata, 32'h0);
    chk("R4", pin_oe[31:0], 32'h0000_0008);

    // R5 set, zeros no effect
    wr(12'h040, 32'h0000_000F);
    wr(12'h040, 32'h0000_0010);
    rd_chk("R5", 12'h000);
    chk("R5", bus_rdata, 32'h0000_001F);
    chk("R8", pin_out[31:0], 32'h0000_001F);

    // R6 clear
    wr(12'h060, 32'h0000_0003);
    rd_chk("R6", 12'h000);
    chk("R6", bus_rdata, 32'h0000_001C);

    // R7 partial lock
    wr(12'h520, 32'h00A5_A501);
    wr(12'h500, 32'h0000_0010);
    wr(12'h060, 32'h0000_001C);
    rd_chk("R7", 12'h000);
    chk("R7", bus_rdata, 32'h0000_0010);
    wr(12'h110, 32'h0);
    rd_chk("R7", 12'h110);
    chk("R7", bus_rdata, 32'h1);

    // R3 intervening write disarms; wrong key does not arm
    wr(12'h520, 32'h00A5_A501);
    wr(12'h040, 32'h0);
    wr(12'h500, 32'h0);
    rd_chk("R3", 12'h500);
    chk("R3", bus_rdata, 32'h0000_0010);
    wr(12'h520, 32'h00A5_A500);
    wr(12'h500, 32'h0);
    rd_chk("R3", 12'h500);
    chk("R3", bus_rdata, 32'h0000_0010);
    // R3 idle cycles keep the arming
    wr(12'h520, 32'h00A5_A501);
    repeat (4) @(negedge clk);
    wr(12'h500, 32'h0);
    rd_chk("R3", 12'h500);
    chk("R3", bus_rdata, 32'h0);

    // R9 two-edge synchronizer
    @(negedge clk);
    bus_addr = 12'h024;
    pin_in[63:32] = 32'hCAFE_F00D;
    @(negedge clk); #1;
    chk("R9", bus_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R9", bus_rdata, 32'hCAFE_F00D);

    // R10 unmapped reads
    rd_chk("R10", 12'h520);
    rd_chk("R10", 12'h501);
    rd_chk("R10", 12'h080);
    rd_chk("R10", 12'h7FC);
    chk("R10", bus_rdata, 32'h0);

    // random phase
    pin_in = {NB{32'h5A3C_96E1}};
    repeat (3) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d = $urandom;
      int b = $urandom_range(NB-1, 0);
      case ($urandom_range(6, 0))
        0: begin a = 12'h520; if ($urandom_range(1, 0) == 1) d = 32'h00A5_A501; end
        1: a = 12'h500 + 12'(4*b);
        2: a = 12'h040 + 12'(4*b);
        3: a = 12'h060 + 12'(4*b);
        4: a = 12'h100 + 12'(4*$urandom_range(NP-1, 0));
        5: begin a = 12'h520; d = 32'h00A5_A501; end
        default: a = 12'($urandom);
      endcase
      wr(a, d);
      pins_chk("R8");
      rd_chk(tag_of(a), a);
      begin
        logic [11:0] ra = 12'($urandom);
        rd_chk(tag_of(ra), ra);
      end
    end
    for (int b = 0; b < NB; b++) begin
      rd_chk("R2", 12'h500 + 12'(4*b));
      rd_chk("R9", 12'h020 + 12'(4*b));
    end
    finish_run();
  end
endmodule